// File: doc/BRIEF.md
# Two-Frame Controlled Slip Buffer

This block is an elastic store that decouples a serial bit stream arriving on a line timebase from the timebase that reads it out. Both sides run from one clock. A write enable marks each line bit and a read enable marks each system bit. The store holds exactly two frames, and both pointers run around a ring of twice the frame length. A frame is 193 bits in the 24-channel mode and 256 bits in the 32-timeslot mode.

The read side checks the distance to the write pointer only when it has just read the last bit of a frame. If the writer is only a few bits ahead, the reader is about to overtake it. If the writer is almost two frames ahead, it is about to lap the reader. In either case the read pointer jumps by one whole frame, so that frame alignment is kept. The block then reports whether a frame was repeated or deleted, with a one-cycle pulse, a direction flag and a sticky flag. The initial distance between the pointers is set by a delay input that is loaded at reset. A bypass input routes the written bit straight to the output and suppresses slips.

Top module: `slip_buffer`

## Requirements
- R1: During and after a synchronous active-low reset, `rd_data` (when not bypassed), `slip_pulse`, `slip_dir` and `slip_sticky` are 0, and every storage bit reads back as 0.
- R2: The write pointer starts at `rd_delay` and the read pointer starts at 0. If `rd_delay` is not below two frame lengths, one frame length is used instead. At equal rates, the bit from the k-th write (counting from 0) appears at `rd_data` after the read numbered `rd_delay`+k. Each read updates `rd_data` on the edge that performs it, and the read sees the storage contents from before a write to the same address in that cycle.
- R3: Frame length is 193 bits when `mode_e1`=0 and 256 bits when `mode_e1`=1. Both pointers wrap at twice that length. The mode is sampled at reset.
- R4: A slip can only occur on a read of a frame's last bit, i.e. at a read count since reset that is a multiple of the frame length. After the slip, the read pointer sits at a frame start.
- R5: Let the gap be the ring distance from the next frame start to the write pointer, taken before that cycle's write. If the gap is below `SLIP_GUARD`, the frame just read is read again. This is a repeat, and `slip_dir` becomes 0.
- R6: If the gap exceeds twice the frame length minus `SLIP_GUARD`, the read pointer skips a frame. This is a delete, and `slip_dir` becomes 1.
- R7: `slip_pulse` is high for exactly the one cycle after the edge that made the slip decision. `slip_dir` holds the direction of the last slip.
- R8: A slip sets `slip_sticky`. `clr_sticky` clears it, but a slip in the same cycle takes precedence over the clear.
- R9: While `bypass`=1, `rd_data` equals `wr_data` combinationally and no slip is taken.
- R10: With `rd_delay` equal to one frame, a rate offset of up to one frame minus `SLIP_GUARD` bits in either direction is absorbed without a slip. This is at least 142 bits in the 193-bit mode and at least 104 bits in the 256-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both timebases |
| rst_n | input | 1 | Synchronous active-low reset; loads mode and delay |
| mode_e1 | input | 1 | 0: 193-bit frames, 1: 256-bit frames |
| rd_delay | input | PTR_W | Initial write pointer, i.e. read delay in bits |
| bypass | input | 1 | Route wr_data to rd_data and suppress slips |
| wr_en | input | 1 | Line bit strobe |
| wr_data | input | 1 | Line bit |
| rd_en | input | 1 | System bit strobe |
| rd_data | output | 1 | System bit |
| slip_pulse | output | 1 | One-cycle slip event |
| slip_dir | output | 1 | Last slip direction: 1 delete, 0 repeat |
| slip_sticky | output | 1 | Set by a slip, cleared by clr_sticky |
| clr_sticky | input | 1 | Clear strobe for slip_sticky |

## Verification
The bench builds the block with its default parameters: 193- and 256-bit frames, a guard of 4 bits and a 9-bit pointer. Both frame lengths are reached through the mode input, and each is run at equal rates, writer-fast and reader-fast. At these sizes several slips of each direction fit within a few thousand cycles of one-in-eight rate skew. A 150-bit pre-offset checks the wander margin. An out-of-range delay of 500 exercises the clamp to one frame.

// File: rtl/slip_pkg.sv
package slip_pkg;
  // Frame length selected by the mode bit.
  function automatic int unsigned frame_bits(input logic e1, input int unsigned t1_len,
                                             input int unsigned e1_len);
    return e1 ? e1_len : t1_len;
  endfunction

  // Next position on a ring of the given span.
  function automatic int unsigned ring_step(input int unsigned ptr, input int unsigned span);
    return (ptr + 1 == span) ? 0 : ptr + 1;
  endfunction

  // Position plus an offset below the span, wrapped once.
  function automatic int unsigned ring_add(input int unsigned ptr, input int unsigned ofs,
                                           input int unsigned span);
    return (ptr + ofs >= span) ? ptr + ofs - span : ptr + ofs;
  endfunction

  // Distance travelled from lag forward to lead on the ring.
  function automatic int unsigned ring_dist(input int unsigned lead, input int unsigned lag,
                                            input int unsigned span);
    return (lead >= lag) ? lead - lag : lead + span - lag;
  endfunction
endpackage

// File: rtl/slip_wr_ptr.sv
module slip_wr_ptr #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  int unsigned      fl,
  input  logic [PTR_W-1:0] start_ofs,
  output logic [PTR_W-1:0] wr_ptr
);
  import slip_pkg::*;

  int unsigned span;
  logic [PTR_W-1:0] load_val;

  always_comb begin
    span = 2 * fl;
    load_val = (32'(start_ofs) >= span) ? PTR_W'(fl) : start_ofs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_ptr <= load_val;
    else if (wr_en)
      wr_ptr <= PTR_W'(ring_step(32'(wr_ptr), span));
  end
endmodule

// File: rtl/slip_store.sv
module slip_store #(
  parameter int DEPTH = 512,
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             wr_data,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic             rd_q
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= '0;
      rd_q  <= 1'b0;
    end else begin
      if (wr_en) cells[wr_ptr] <= wr_data;
      if (rd_en) rd_q <= cells[rd_ptr];
    end
  end
endmodule

// File: rtl/slip_rd_ctrl.sv
module slip_rd_ctrl #(
  parameter int PTR_W      = 9,
  parameter int SLIP_GUARD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             bypass,
  input  logic             clr_sticky,
  input  int unsigned      fl,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             frame_end,
  output logic             slip_go,
  output logic             slip_del,
  output logic             slip_pulse,
  output logic             slip_dir,
  output logic             slip_sticky
);
  import slip_pkg::*;

  int unsigned span, next_start, gap, jump_to;
  logic near_under, near_over;

  always_comb begin
    span       = 2 * fl;
    frame_end  = rd_en && ((32'(rd_ptr) == fl - 1) || (32'(rd_ptr) == span - 1));
    next_start = (32'(rd_ptr) == span - 1) ? 0 : fl;
    gap        = ring_dist(32'(wr_ptr), next_start, span);
    near_under = gap < SLIP_GUARD;
    near_over  = gap > span - SLIP_GUARD;
    slip_go    = frame_end && !bypass && (near_under || near_over);
    slip_del   = near_over;
    jump_to    = ring_add(next_start, fl, span);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr      <= '0;
      slip_pulse  <= 1'b0;
      slip_dir    <= 1'b0;
      slip_sticky <= 1'b0;
    end else begin
      if (slip_go)
        rd_ptr <= PTR_W'(jump_to);
      else if (rd_en)
        rd_ptr <= PTR_W'(ring_step(32'(rd_ptr), span));
      slip_pulse  <= slip_go;
      if (slip_go) slip_dir <= slip_del;
      slip_sticky <= slip_go || (slip_sticky && !clr_sticky);
    end
  end
endmodule

// File: rtl/slip_buffer.sv
module slip_buffer #(
  parameter int T1_LEN     = 193,
  parameter int E1_LEN     = 256,
  parameter int SLIP_GUARD = 4,
  parameter int PTR_W      = $clog2(2 * E1_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_e1,
  input  logic [PTR_W-1:0] rd_delay,
  input  logic             bypass,
  input  logic             wr_en,
  input  logic             wr_data,
  input  logic             rd_en,
  output logic             rd_data,
  output logic             slip_pulse,
  output logic             slip_dir,
  output logic             slip_sticky,
  input  logic             clr_sticky
);
  localparam int DEPTH = 2 * E1_LEN;

  logic              mode_q;
  int unsigned       fl;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              rd_q, frame_end, slip_go, slip_del;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_e1;
  end

  assign fl = slip_pkg::frame_bits(rst_n ? mode_q : mode_e1, T1_LEN, E1_LEN);

  slip_wr_ptr #(.PTR_W(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fl(fl),
    .start_ofs(rd_delay), .wr_ptr(wr_ptr)
  );

  slip_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_q(rd_q)
  );

  slip_rd_ctrl #(.PTR_W(PTR_W), .SLIP_GUARD(SLIP_GUARD)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .bypass(bypass), .clr_sticky(clr_sticky),
    .fl(fl), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .frame_end(frame_end),
    .slip_go(slip_go), .slip_del(slip_del), .slip_pulse(slip_pulse),
    .slip_dir(slip_dir), .slip_sticky(slip_sticky)
  );

  assign rd_data = bypass ? wr_data : rd_q;
endmodule

// File: rtl/slip_chk.sv
module slip_chk #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             bypass,
  input logic             slip_pulse,
  input logic             slip_sticky,
  input logic             frame_end,
  input int unsigned      fl,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] wr_ptr
);
  // R3: both pointers stay on the two-frame ring
  assert_ptr_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wr_ptr) < 2 * fl) && (32'(rd_ptr) < 2 * fl));

  // R4: a slip lands the read pointer on a frame start
  assert_slip_on_frame_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> (rd_ptr == '0 || 32'(rd_ptr) == fl));

  // R4: a slip follows a frame-ending read
  assert_slip_after_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && slip_pulse |-> $past(frame_end));

  // R7: the event lasts a single cycle
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  // R8: every slip leaves the sticky flag set
  assert_sticky_on_slip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> slip_sticky);

  // R9: no slip while bypassed
  assert_bypass_no_slip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bypass) |-> !slip_pulse);
endmodule

bind slip_buffer slip_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .bypass(bypass), .slip_pulse(slip_pulse),
  .slip_sticky(slip_sticky), .frame_end(frame_end), .fl(fl), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/test_slip_buffer.sv
module test_slip_buffer;
  localparam int G = 4;

  logic clk = 0, rst_n = 0, mode_e1 = 0, bypass = 0;
  logic wr_en = 0, wr_data = 0, rd_en = 0, clr_sticky = 0;
  logic [8:0] rd_delay = 9'd193;
  logic rd_data, slip_pulse, slip_dir, slip_sticky;

  slip_buffer i_slip_buffer (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .rd_delay(rd_delay), .bypass(bypass),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .slip_pulse(slip_pulse), .slip_dir(slip_dir), .slip_sticky(slip_sticky),
    .clr_sticky(clr_sticky)
  );

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  // Behavioural reference
  bit m_mem[512];
  int wp, rp, rq, pulse, dir, sticky, flm, span, reads;
  int n_del, n_rep;

  always @(posedge clk) begin
    if (!rst_n) begin
      flm = mode_e1 ? 256 : 193;
      span = 2 * flm;
      wp = (int'(rd_delay) >= span) ? flm : int'(rd_delay);
      rp = 0; rq = 0; pulse = 0; dir = 0; sticky = 0; reads = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      int set;
      set = 0;
      pulse = 0;
      if (rd_en) begin
        rq = m_mem[rp];
        reads++;
        if (rp % flm == flm - 1) begin
          int base, gap;
          base = (rp + 1) % span;
          gap = (wp - base + span) % span;
          if (!bypass && (gap < G || gap > span - G)) begin
            set = 1; pulse = 1; dir = (gap > span - G);
            rp = (base + flm) % span;
          end else rp = base;
        end else rp = (rp + 1) % span;
      end
      sticky = set | (sticky & !clr_sticky);
      if (wr_en) begin
        m_mem[wp] = wr_data;
        wp = (wp + 1) % span;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Compare at the falling edge, then drive the next inputs.
  task automatic step(input bit w, input bit r);
    @(negedge clk);
    chk(rd_data === (bypass ? wr_data : rq[0]), "R2 rd_data", int'(rd_data),
        bypass ? int'(wr_data) : rq);
    chk(slip_pulse === pulse[0], "R7 slip_pulse", int'(slip_pulse), pulse);
    chk(slip_dir === dir[0], "R5/R6 slip_dir", int'(slip_dir), dir);
    chk(slip_sticky === sticky[0], "R8 slip_sticky", int'(slip_sticky), sticky);
    if (slip_pulse === 1'b1 && rst_n) begin
      chk(reads % flm == 0, "R4 slip on frame boundary", reads % flm, 0);
      if (slip_dir) n_del++; else n_rep++;
    end
    wr_en = w; rd_en = r; wr_data = 1'($urandom);
    clr_sticky = 0;
  endtask

  task automatic do_reset(input bit e1, input int dly);
    @(negedge clk);
    rst_n = 0; mode_e1 = e1; rd_delay = 9'(dly); wr_en = 0; rd_en = 0; bypass = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_del = 0; n_rep = 0;
  endtask

  // skew: 0 equal, 1 read skips every 8th, 2 write skips every 8th
  task automatic run(input int n, input int skew);
    for (int i = 0; i < n; i++)
      step(!(skew == 2 && i % 8 == 7), !(skew == 1 && i % 8 == 7));
  endtask

  initial begin
    // R1: reset state
    do_reset(0, 193);
    @(negedge clk);
    chk(rd_data === 0 && slip_pulse === 0 && slip_sticky === 0 && slip_dir === 0,
        "R1 reset outputs", int'({rd_data, slip_pulse, slip_sticky, slip_dir}), 0);
    run(420, 0);  // R1: first reads return cleared storage, compared by model

    // R2: small delay, equal rates
    do_reset(0, 10);
    run(1200, 0);
    chk(n_del + n_rep == 0, "R2 no slip at equal rate", n_del + n_rep, 0);

    // R10: 150-bit lead absorbed in 193-bit mode
    do_reset(0, 193);
    run(150, 0);
    for (int i = 0; i < 150; i++) step(1, 0);
    run(1000, 0);
    chk(n_del + n_rep == 0, "R10 wander absorbed", n_del + n_rep, 0);

    // R6, R3: writer fast in 193-bit mode -> deletes
    do_reset(0, 193);
    run(5000, 1);
    chk(n_del >= 2, "R6 deletes when writer fast", n_del, 2);
    chk(n_rep == 0, "R6 no repeats when writer fast", n_rep, 0);

    // R8: clear, then clear ignored when slip coincides handled by model
    @(negedge clk); clr_sticky = 1; wr_en = 1; rd_en = 1;
    @(negedge clk);
    chk(slip_sticky === 0, "R8 sticky cleared", int'(slip_sticky), 0);
    clr_sticky = 0;

    // R5: reader fast in 193-bit mode -> repeats
    do_reset(0, 193);
    run(5000, 2);
    chk(n_rep >= 2, "R5 repeats when reader fast", n_rep, 2);
    chk(n_del == 0, "R5 no deletes when reader fast", n_del, 0);

    // R3, R6: 256-bit mode writer fast
    do_reset(1, 256);
    run(6000, 1);
    chk(n_del >= 2, "R3 deletes in 256-bit mode", n_del, 2);

    // R3, R5: 256-bit mode reader fast
    do_reset(1, 256);
    run(6000, 2);
    chk(n_rep >= 2, "R3 repeats in 256-bit mode", n_rep, 2);

    // R10: 104-bit lag absorbed in 256-bit mode
    do_reset(1, 256);
    for (int i = 0; i < 104; i++) step(0, 1);
    run(1200, 0);
    chk(n_del + n_rep == 0, "R10 lag absorbed 256-bit", n_del + n_rep, 0);

    // R2: out-of-range delay clamps to one frame
    do_reset(0, 500);
    run(1000, 0);
    chk(n_del + n_rep == 0, "R2 clamped delay no slip", n_del + n_rep, 0);

    // R9: bypass with strong skew, no slips
    do_reset(0, 193);
    @(negedge clk); bypass = 1;
    run(4000, 1);
    chk(n_del + n_rep == 0, "R9 no slip in bypass", n_del + n_rep, 0);
    chk(slip_sticky === 0, "R9 sticky untouched", int'(slip_sticky), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule